// File: doc/BRIEF.md
# Fixed-Point Inverse Cosine Pipeline

This block gives an approximate inverse cosine of an unsigned 8-bit fraction. The input code `in_x` stands for the value in_x/256 on the interval from 0 to just under 1. The result `out_angle` is an unsigned 10-bit angle in tenths of a degree. The block uses only integer hardware: a chain of multiplies, constant additions, one constant subtraction and right shifts by fixed amounts. Each shift drops its low bits, so every quotient is the floor of the exact one. The evaluation order is fixed:
`sq = x*x`, `p1 = (86*sq)>>16`, `s1 = 191+p1`, `p2 = (s1*sq)>>16`, `s2 = 1144+p2`, `p3 = (s2*x)>>9`, `angle = 900-p3`.

Each of the seven steps has its own register stage. The input code is carried forward in a delay line until the sixth step needs it again, and the square is carried until the fourth step needs it. A caller presents a code with `in_valid` on any cycle. Back-to-back codes are allowed. The matching angle appears with `out_valid` a fixed seven clocks later. Accuracy is poor near the top of the input range, and the block makes no correction for this.

Top module: `acos_poly_pipe`

## Requirements
- R1: For every input code 0..255 accepted with `in_valid`, `out_angle` equals the truncating integer formula given above.
- R2: Input code 0 yields an angle of 900.
- R3: Input code 128 yields an angle of 601.
- R4: Input code 255 yields the smallest angle, 195, and every valid output lies between 195 and 900 inclusive.
- R5: Each right shift gives the floor of the exact quotient, so each shifted result r satisfies r*2^k <= product < (r+1)*2^k.
- R6: `out_valid` is high exactly 7 clock edges after the edge that sampled `in_valid` high.
- R7: A new code may be accepted on every clock, and back-to-back codes come out on consecutive cycles in input order.
- R8: A synchronous active-high `rst` clears every stage's valid flag. `out_valid` is low on the cycle after reset, and codes in flight when reset is asserted never emerge.
- R9: A cycle with `in_valid` low produces a cycle with `out_valid` low 7 clocks later. Gaps in the input stream are preserved.
- R10: No intermediate result exceeds its register width, and the final subtraction never wraps below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_x` as a code to evaluate this cycle |
| in_x | input | 8 | Unsigned input fraction code (value/256) |
| out_valid | output | 1 | Marks `out_angle` as a result |
| out_angle | output | 10 | Angle in tenths of a degree |

## Verification
The embedded assertions check the following on every cycle: the floor property of every multiply-shift stage, the absence of width overflow and subtraction wrap at each stage, the 195..900 output range, the seven-clock valid alignment counted from reset, and the quiet output after reset. The per-code values of the angle can be shown only by the bench scenarios. These are the exhaustive back-to-back sweep, gapped streams that test bubble preservation, single-code latency probes at 0, 128 and 255, and a reset asserted while codes are in flight.

// File: rtl/acos_pkg.sv
package acos_pkg;
  // Input and output widths
  parameter int unsigned XW   = 8;
  parameter int unsigned AW   = 10;
  // Intermediate widths, sized from worst-case values at x = 255
  parameter int unsigned SQW  = 2 * XW;   // square, max 65025
  parameter int unsigned P1W  = 7;        // max 85
  parameter int unsigned S1W  = 9;        // max 276
  parameter int unsigned P2W  = 9;        // max 273
  parameter int unsigned S2W  = 11;       // max 1417
  parameter int unsigned P3W  = 10;       // max 705
  // Constants of the nested polynomial
  parameter int unsigned KMUL = 86;
  parameter int unsigned KMW  = 7;
  parameter int unsigned KS1  = 191;
  parameter int unsigned KS2  = 1144;
  parameter int unsigned KTOP = 900;
  // Shift amounts
  parameter int unsigned SHA  = 16;
  parameter int unsigned SHB  = 16;
  parameter int unsigned SHC  = 9;
  // Pipeline depth
  parameter int unsigned LAT  = 7;
  localparam int unsigned LATW = $clog2(LAT + 1);

  // Floor of (a*b)/2^sh in a wide intermediate
  function automatic logic [63:0] mul_floor(input logic [31:0] a,
                                            input logic [31:0] b,
                                            input int unsigned sh);
    logic [63:0] p;
    p = 64'(a) * 64'(b);
    return p >> sh;
  endfunction

  // Constant plus or minus operand, in a wide intermediate
  function automatic logic [63:0] const_op(input logic [31:0] k,
                                           input logic [31:0] a,
                                           input logic sub);
    return sub ? (64'(k) - 64'(a)) : (64'(k) + 64'(a));
  endfunction
endpackage

// File: rtl/acos_dly.sv
module acos_dly #(
  parameter int unsigned W = 8,
  parameter int unsigned N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] tap [N+1];

  assign tap[0] = d_i;

  for (genvar g = 0; g < N; g++) begin : g_tap
    always_ff @(posedge clk) begin
      if (rst) tap[g+1] <= '0;
      else     tap[g+1] <= tap[g];
    end
  end

  assign q_o = tap[N];
endmodule

// File: rtl/acos_mul_stg.sv
module acos_mul_stg
  import acos_pkg::*;
#(
  parameter int unsigned IAW = 8,
  parameter int unsigned IBW = 8,
  parameter int unsigned OW  = 16,
  parameter int unsigned SH  = 0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_i,
  input  logic [IAW-1:0] a_i,
  input  logic [IBW-1:0] b_i,
  output logic           v_o,
  output logic [OW-1:0]  r_o
);
  localparam int unsigned PRW = IAW + IBW;

  logic [PRW-1:0] prod_w;
  logic [PRW-1:0] shr_w;
  logic           ovf_w;      // shifted product does not fit OW
  logic [PRW:0]   floor_lo_w; // r_o scaled back up
  logic [PRW:0]   step_w;     // 2^SH

  always_comb begin
    prod_w = PRW'(mul_floor(32'(a_i), 32'(b_i), 0));
    shr_w  = prod_w >> SH;
  end

  if (PRW > OW) begin : g_ovf
    assign ovf_w = |shr_w[PRW-1:OW];
  end else begin : g_noovf
    assign ovf_w = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      r_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) r_o <= shr_w[OW-1:0];
    end
  end

  assign floor_lo_w = (PRW+1)'(r_o) << SH;
  assign step_w     = (PRW+1)'(1) << SH;

  // R10: the shifted product fits its register
  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    v_i |-> !ovf_w);

  // R5: registered result is the floor of product / 2^SH
  assert_trunc_floor_R5: assert property (@(posedge clk) disable iff (rst)
    v_o |-> (floor_lo_w <= (PRW+1)'($past(prod_w))) &&
            ((PRW+1)'($past(prod_w)) - floor_lo_w < step_w));
endmodule

// File: rtl/acos_addk_stg.sv
module acos_addk_stg
  import acos_pkg::*;
#(
  parameter int unsigned IW  = 8,
  parameter int unsigned OW  = 9,
  parameter int unsigned K   = 0,
  parameter bit          SUB = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_i,
  input  logic [IW-1:0] a_i,
  output logic          v_o,
  output logic [OW-1:0] r_o
);
  localparam int unsigned SW = OW + 2;

  logic [SW-1:0] full_w;
  logic          wrap_w;   // result left the OW range (overflow or borrow)

  always_comb full_w = SW'(const_op(32'(K), 32'(a_i), SUB));
  assign wrap_w = |full_w[SW-1:OW];

  always_ff @(posedge clk) begin
    if (rst) begin
      v_o <= 1'b0;
      r_o <= '0;
    end else begin
      v_o <= v_i;
      if (v_i) r_o <= full_w[OW-1:0];
    end
  end

  // R10: no wrap through the constant stage
  assert_no_wrap_R10: assert property (@(posedge clk) disable iff (rst)
    v_i |-> !wrap_w);

  if (SUB) begin : g_sub_chk
    // R10: a subtracting stage never sees an operand above its constant
    assert_no_borrow_R10: assert property (@(posedge clk) disable iff (rst)
      v_o |-> (32'($past(a_i)) <= 32'(K)));
  end
endmodule

// File: rtl/acos_poly_pipe.sv
module acos_poly_pipe
  import acos_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [XW-1:0] in_x,
  output logic          out_valid,
  output logic [AW-1:0] out_angle
);
  logic           v1, v2, v3, v4, v5, v6;
  logic [SQW-1:0] sq1, sq3;
  logic [P1W-1:0] p1;
  logic [S1W-1:0] s1;
  logic [P2W-1:0] p2;
  logic [S2W-1:0] s2;
  logic [P3W-1:0] p3;
  logic [XW-1:0]  x5;

  // Step 1: square
  acos_mul_stg #(.IAW(XW), .IBW(XW), .OW(SQW), .SH(0)) u_sq (
    .clk(clk), .rst(rst), .v_i(in_valid), .a_i(in_x), .b_i(in_x),
    .v_o(v1), .r_o(sq1));

  // Square waits two stages for step 4
  acos_dly #(.W(SQW), .N(2)) u_sq_dly (
    .clk(clk), .rst(rst), .d_i(sq1), .q_o(sq3));

  // Input code waits five stages for step 6
  acos_dly #(.W(XW), .N(5)) u_x_dly (
    .clk(clk), .rst(rst), .d_i(in_x), .q_o(x5));

  // Step 2: constant multiply and shift
  acos_mul_stg #(.IAW(SQW), .IBW(KMW), .OW(P1W), .SH(SHA)) u_p1 (
    .clk(clk), .rst(rst), .v_i(v1), .a_i(sq1), .b_i(KMW'(KMUL)),
    .v_o(v2), .r_o(p1));

  // Step 3: add first constant
  acos_addk_stg #(.IW(P1W), .OW(S1W), .K(KS1), .SUB(1'b0)) u_s1 (
    .clk(clk), .rst(rst), .v_i(v2), .a_i(p1), .v_o(v3), .r_o(s1));

  // Step 4: multiply by square and shift
  acos_mul_stg #(.IAW(S1W), .IBW(SQW), .OW(P2W), .SH(SHB)) u_p2 (
    .clk(clk), .rst(rst), .v_i(v3), .a_i(s1), .b_i(sq3),
    .v_o(v4), .r_o(p2));

  // Step 5: add second constant
  acos_addk_stg #(.IW(P2W), .OW(S2W), .K(KS2), .SUB(1'b0)) u_s2 (
    .clk(clk), .rst(rst), .v_i(v4), .a_i(p2), .v_o(v5), .r_o(s2));

  // Step 6: multiply by input code and shift
  acos_mul_stg #(.IAW(S2W), .IBW(XW), .OW(P3W), .SH(SHC)) u_p3 (
    .clk(clk), .rst(rst), .v_i(v5), .a_i(s2), .b_i(x5),
    .v_o(v6), .r_o(p3));

  // Step 7: subtract from right angle
  acos_addk_stg #(.IW(P3W), .OW(AW), .K(KTOP), .SUB(1'b1)) u_ang (
    .clk(clk), .rst(rst), .v_i(v6), .a_i(p3), .v_o(out_valid), .r_o(out_angle));

  // Cycles since reset, saturating at LAT, to gate the latency check
  logic [LATW-1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                  since_rst <= '0;
    else if (since_rst < LAT) since_rst <= since_rst + 1'b1;
  end

  // R6 / R9: output valid mirrors input valid seven edges earlier
  assert_latency_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst == LATW'(LAT)) |-> (out_valid == $past(in_valid, 7)));

  // R4: results stay inside the reachable angle range
  assert_out_range_R4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_angle >= AW'(195)) && (out_angle <= AW'(KTOP)));

  // R8: nothing emerges on the cycle after reset
  assert_reset_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);
endmodule

// File: tb/acos_poly_pipe_tb.sv
module acos_poly_pipe_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] in_x = '0;
  logic       out_valid;
  logic [9:0] out_angle;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  acos_poly_pipe u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_angle(out_angle));

  // Reference written with integer division instead of shifts
  function automatic int ref_angle(input int x);
    int q, p1, s1, p2, s2, p3;
    q  = x * x;
    p1 = (86 * q) / 65536;
    s1 = 191 + p1;
    p2 = (s1 * q) / 65536;
    s2 = 1144 + p2;
    p3 = (s2 * x) / 512;
    return 900 - p3;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // Behavioural model: queue of what was sampled on each edge
  bit hv[$];
  int hx[$];
  bit model_on = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      hv.delete(); hx.delete();
      for (int i = 0; i < 7; i++) begin hv.push_back(1'b0); hx.push_back(0); end
    end else begin
      hv.push_front(in_valid); hx.push_front(int'(in_x));
      void'(hv.pop_back()); void'(hx.pop_back());
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (model_on && !rst && hv.size() == 7) begin
      chk(out_valid == hv[6], "R7/R9 valid", int'(out_valid), int'(hv[6]));
      if (hv[6])
        chk(int'(out_angle) == ref_angle(hx[6]), "R1/R5 angle",
            int'(out_angle), ref_angle(hx[6]));
    end
  end

  task automatic probe(input int x, input int exp, input string tag);
    int lat;
    @(negedge clk); in_valid = 1'b1; in_x = 8'(x);
    @(negedge clk); in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 20) begin @(negedge clk); lat++; end
    chk(lat == 7, "R6 latency", lat, 7);
    chk(int'(out_angle) == exp, tag, int'(out_angle), exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 reset state", int'(out_valid), 0);
    model_on = 1'b1;

    probe(0,   900, "R2 zero");
    probe(128, 601, "R3 half");
    probe(255, 195, "R4/R10 top code");
    probe(1,   898, "R5 small code");
    repeat (3) @(negedge clk);

    // R7: exhaustive back-to-back stream
    for (int x = 0; x < 256; x++) begin
      in_valid = 1'b1; in_x = 8'(x);
      @(negedge clk);
    end
    in_valid = 1'b0;
    repeat (10) @(negedge clk);

    // R9: gapped stream, valid every other or every third cycle
    for (int x = 255; x >= 0; x -= 5) begin
      in_valid = 1'b1; in_x = 8'(x);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (1 + (x % 2)) @(negedge clk);
    end
    repeat (10) @(negedge clk);

    // R8: reset while codes are in flight
    for (int x = 10; x < 14; x++) begin
      in_valid = 1'b1; in_x = 8'(x);
      @(negedge clk);
    end
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 9; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R8 flushed", int'(out_valid), 0);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end
endmodule